// File: doc/BRIEF.md
# Key-Guarded Clock Configuration Register

This block is an 8-bit, memory-mapped clock configuration register on a simple CPU write bus. The bus has an address, write data and a write strobe. Ordinary writes to the register have no effect. To change it, software first writes an unlock key. The write that comes right after the key is then treated as a command. That command either requests a one-cycle reset of the clock prescaler or loads the three clock-source selection bits.

The selection bits drive three configuration outputs:
- the main-clock undivided enable,
- the main-clock external-input select,
- the sub-clock external-input select.

A fourth output is the prescaler-reset pulse. A read view shows the register as software sees it: the upper nibble is zero, bit 3 is fixed high, and bits 2..0 hold the selection.

The guard is a two-state machine:
- `ST_LOCKED`: the register is disarmed. A key write to the register's address moves it to `ST_ARMED` (transition *unlock*). Any other write leaves it in `ST_LOCKED` (transition *reject*).
- `ST_ARMED`: the next write of any kind returns it to `ST_LOCKED` (transition *consume*). Cycles with no write keep it in `ST_ARMED` (transition *hold*).

A consumed write to the register's address with the prescaler code asserts the pulse. A consumed write with a zero upper nibble loads the selection. Any other consumed write is dropped.

Top module: `clkkey_guard`

## Requirements
- R1: After reset the guard is disarmed, all three selection outputs are 0, the prescaler pulse is 0, and the read view is 0x08.
- R2: The read view always shows 0 in bits 7..4, 1 in bit 3, and the selection in bits 2..0: bit 0 is main undivided, bit 1 is main external, bit 2 is sub external.
- R3: While disarmed, a write of any value other than 0x55 to address 0x6F, or a write of any value to another address, leaves the selection and the pulse unchanged.
- R4: A write of 0x55 to address 0x6F while disarmed arms the guard. A 0x55 write to any other address does not arm it.
- R5: An armed write to 0x6F whose bits 7..4 are zero loads its bits 2..0 into the selection. The outputs show the new value in the cycle after the write's clock edge.
- R6: An armed write of 0x80 to 0x6F raises the prescaler pulse for exactly the one cycle after the write's clock edge, and leaves the selection unchanged.
- R7: Any write while armed disarms the guard, whatever its address or data. An armed write to 0x6F of any value other than 0x80 or 0x0Y (0x55 included) changes nothing.
- R8: Cycles with no write leave the armed state in place, and the prescaler pulse is never high except as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| main_undiv | output | 1 | 1: main clock is not divided by two |
| main_ext | output | 1 | 1: main clock is taken from the external input |
| sub_ext | output | 1 | 1: sub clock is taken from the external input |
| presc_rst | output | 1 | One-cycle prescaler reset pulse |
| cfg_view | output | 8 | Register contents as read back |

## Verification
The bench targets five corner cases:
- A key sent to the wrong address. A design that decodes only the data would arm here and then load the next write.
- A foreign-address write between the key and the command. A design that disarms only on its own address would accept the following command.
- Idle cycles between the key and the command. A design that disarms on a timeout would drop a legal command.
- A second key write while armed. A design that treats it as a re-arm would accept the write after it.
- The prescaler command. The bench checks that it does not leak into the selection and that its pulse lasts exactly one cycle.

Random traffic weighted towards key and command writes then mixes these sequences.

// File: rtl/clkkey_pkg.sv
package clkkey_pkg;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_ARMED  = 1'b1
    } guard_state_t;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_KEY   = 2'd1,
        CMD_PRESC = 2'd2,
        CMD_LOAD  = 2'd3
    } guard_cmd_t;

endpackage

// File: rtl/clkkey_decode.sv
module clkkey_decode
    import clkkey_pkg::*;
#(
    parameter int          AW         = 8,
    parameter int          DW         = 8,
    parameter int          LOAD_LSB   = 4,
    parameter logic [AW-1:0] REG_ADDR = 8'h6F,
    parameter logic [DW-1:0] KEY_CODE = 8'h55,
    parameter logic [DW-1:0] PRESC_CODE = 8'h80
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          any_wr,
    output guard_cmd_t    cmd
);
    localparam int HI_W = DW - LOAD_LSB;

    logic hit;
    assign hit    = wr_en && (wr_addr == REG_ADDR);
    assign any_wr = wr_en;

    always_comb begin
        cmd = CMD_NONE;
        if (hit) begin
            if (wr_data == KEY_CODE)
                cmd = CMD_KEY;
            else if (wr_data == PRESC_CODE)
                cmd = CMD_PRESC;
            else if (wr_data[DW-1:LOAD_LSB] == HI_W'(0))
                cmd = CMD_LOAD;
        end
    end
endmodule

// File: rtl/clkkey_fsm.sv
module clkkey_fsm
    import clkkey_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_wr,
    input  guard_cmd_t cmd,
    output logic       armed,
    output logic       take_load,
    output logic       take_presc
);
    guard_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_LOCKED;
        else
            state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        take_load  = 1'b0;
        take_presc = 1'b0;
        unique case (state_q)
            ST_LOCKED: begin
                if (cmd == CMD_KEY)
                    state_d = ST_ARMED;      // unlock
            end
            ST_ARMED: begin
                if (any_wr) begin
                    state_d    = ST_LOCKED;  // consume
                    take_load  = (cmd == CMD_LOAD);
                    take_presc = (cmd == CMD_PRESC);
                end
            end
        endcase
    end

    assign armed = (state_q == ST_ARMED);
endmodule

// File: rtl/clkkey_store.sv
module clkkey_store #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_load,
    input  logic             take_presc,
    input  logic [SEL_W-1:0] load_val,
    output logic [SEL_W-1:0] sel_q,
    output logic             pulse_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= take_presc;
            if (take_load)
                sel_q <= load_val;
        end
    end
endmodule

// File: rtl/clkkey_guard.sv
module clkkey_guard
    import clkkey_pkg::*;
#(
    parameter int            AW         = 8,
    parameter int            DW         = 8,
    parameter int            SEL_W      = 3,
    parameter logic [AW-1:0] REG_ADDR   = 8'h6F,
    parameter logic [DW-1:0] KEY_CODE   = 8'h55,
    parameter logic [DW-1:0] PRESC_CODE = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          main_undiv,
    output logic          main_ext,
    output logic          sub_ext,
    output logic          presc_rst,
    output logic [DW-1:0] cfg_view
);
    localparam int LOAD_LSB = SEL_W + 1;
    localparam int PAD_W    = DW - LOAD_LSB;

    guard_cmd_t       cmd;
    logic             any_wr;
    logic             armed;
    logic             take_load;
    logic             take_presc;
    logic [SEL_W-1:0] sel_q;

    clkkey_decode #(
        .AW(AW), .DW(DW), .LOAD_LSB(LOAD_LSB),
        .REG_ADDR(REG_ADDR), .KEY_CODE(KEY_CODE), .PRESC_CODE(PRESC_CODE)
    ) dec_i (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .any_wr(any_wr), .cmd(cmd)
    );

    clkkey_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .any_wr(any_wr), .cmd(cmd),
        .armed(armed), .take_load(take_load), .take_presc(take_presc)
    );

    clkkey_store #(.SEL_W(SEL_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .take_load(take_load), .take_presc(take_presc),
        .load_val(wr_data[SEL_W-1:0]),
        .sel_q(sel_q), .pulse_q(presc_rst)
    );

    assign main_undiv = sel_q[0];
    assign main_ext   = sel_q[1];
    assign sub_ext    = sel_q[2];
    assign cfg_view   = {PAD_W'(0), 1'b1, sel_q};
endmodule

// File: rtl/clkkey_guard_chk.sv
module clkkey_guard_chk #(
    parameter int            AW         = 8,
    parameter int            DW         = 8,
    parameter logic [AW-1:0] REG_ADDR   = 8'h6F,
    parameter logic [DW-1:0] KEY_CODE   = 8'h55,
    parameter logic [DW-1:0] PRESC_CODE = 8'h80
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic [2:0]    sel,
    input logic          presc_rst,
    input logic          armed
);
    logic hit;
    assign hit = wr_en && (wr_addr == REG_ADDR);

    // R4
    unlock_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && hit && wr_data == KEY_CODE) |=> armed);

    // R7
    write_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en) |=> !armed);

    // R8
    idle_holds_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !wr_en) |=> armed);

    // R5
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && hit && wr_data[DW-1:4] == '0) |=> (sel == $past(wr_data[2:0])));

    // R3
    sel_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed) |=> $stable(sel));

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        presc_rst |=> !presc_rst);

    // R6
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && hit && wr_data == PRESC_CODE) |=> (presc_rst && $stable(sel)));

    // R8
    no_stray_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && hit && wr_data == PRESC_CODE) |=> !presc_rst);
endmodule

bind clkkey_guard clkkey_guard_chk #(
    .AW(AW), .DW(DW), .REG_ADDR(REG_ADDR), .KEY_CODE(KEY_CODE), .PRESC_CODE(PRESC_CODE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel(sel_q), .presc_rst(presc_rst), .armed(armed)
);

// File: tb/clkkey_guard_tb_top.sv
module clkkey_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_REG = 8'h6F;
    localparam logic [7:0] KEY   = 8'h55;
    localparam logic [7:0] PRESC = 8'h80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       main_undiv, main_ext, sub_ext, presc_rst;
    logic [7:0] cfg_view;

    int tests = 0;
    int fails = 0;
    logic       m_arm = 1'b0;
    logic [2:0] m_sel = 3'b000;
    logic       m_pulse = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkkey_guard dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .main_undiv(main_undiv), .main_ext(main_ext), .sub_ext(sub_ext),
        .presc_rst(presc_rst), .cfg_view(cfg_view)
    );

    function automatic logic [7:0] view_of(input logic [2:0] s);
        return {4'b0000, 1'b1, s};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        m_pulse = 1'b0;
        if (we) begin
            if (m_arm) begin
                m_arm = 1'b0;
                if (a == A_REG) begin
                    if (d == PRESC) m_pulse = 1'b1;
                    else if (d[7:4] == 4'h0) m_sel = d[2:0];
                end
            end else if (a == A_REG && d == KEY) begin
                m_arm = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        check({tag, " view"}, cfg_view, view_of(m_sel));
        check({tag, " sel"}, {5'b0, sub_ext, main_ext, main_undiv}, {5'b0, m_sel});
        check({tag, " R6 pulse"}, {7'b0, presc_rst}, {7'b0, m_pulse});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 view", cfg_view, 8'h08);
        check("R1 outs", {4'b0, main_undiv, main_ext, sub_ext, presc_rst}, 8'h00);
        // R3 unarmed write ignored; R1 starts disarmed
        step(1'b1, A_REG, 8'h03, "R3 unarmed");
        step(1'b1, 8'h20, 8'h07, "R3 other addr");
        // R5 load
        step(1'b1, A_REG, KEY, "R4 key");
        step(1'b1, A_REG, 8'h05, "R5 load 05");
        // R4 key to wrong address does not arm
        step(1'b1, 8'h6E, KEY, "R4 wrong addr key");
        step(1'b1, A_REG, 8'h03, "R4 not armed");
        // R7 foreign write consumes arm
        step(1'b1, A_REG, KEY, "R7 key");
        step(1'b1, 8'h10, 8'h02, "R7 foreign");
        step(1'b1, A_REG, 8'h02, "R7 after consume");
        // R8 idle keeps arm
        step(1'b1, A_REG, KEY, "R8 key");
        step(1'b0, A_REG, 8'h00, "R8 idle");
        step(1'b0, 8'h00, 8'h00, "R8 idle");
        step(1'b0, 8'h00, 8'h00, "R8 idle");
        step(1'b1, A_REG, 8'h06, "R8 load after idle");
        // R6 prescaler pulse
        step(1'b1, A_REG, KEY, "R6 key");
        step(1'b1, A_REG, PRESC, "R6 presc");
        step(1'b0, 8'h00, 8'h00, "R6 after");
        // R7 double key
        step(1'b1, A_REG, KEY, "R7 key1");
        step(1'b1, A_REG, KEY, "R7 key2");
        step(1'b1, A_REG, 8'h01, "R7 after double key");
        // R7 non-command armed value
        step(1'b1, A_REG, KEY, "R7 key");
        step(1'b1, A_REG, 8'h13, "R7 junk");
        // R5 upper Y bit ignored, R2 bit 3 stays 1
        step(1'b1, A_REG, KEY, "R5 key");
        step(1'b1, A_REG, 8'h0F, "R2 R5 load 0F");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int k;
            logic [7:0] d;
            k = $urandom % 10;
            d = 8'($urandom);
            case (k)
                0, 1, 2: step(1'b1, A_REG, KEY, "R4 rnd key");
                3:       step(1'b1, A_REG, PRESC, "R6 rnd presc");
                4:       step(1'b1, A_REG, {4'h0, d[3:0]}, "R5 rnd load");
                5:       step(1'b1, A_REG, d, "R7 rnd data");
                6:       step(1'b1, 8'($urandom % 2 ? 8'h6E : d), (d[0] ? KEY : d), "R3 rnd addr");
                default: step(1'b0, d, d, "R8 rnd idle");
            endcase
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule